// File: doc/BRIEF.md
# Wrapping Burst Beat Sequencer

This block runs the data phase of a master on a 64-bit system bus. It moves a 32-byte cache line as four 8-byte beats. It also carries single aligned transfers of 1, 2, 4 or 8 bytes. When the address phase hands it a request, the block latches the address and the direction. It then steps through the beats, advancing once for each transfer acknowledge it receives from the bus.

In a burst, the block presents the double-word index of the current beat, the matching beat address and all eight byte lanes. A read begins at the double-word the requester needs first and wraps around the line. A write always begins at double-word zero.

In a single transfer, the block first checks that the address is a multiple of the size. If it is, the block drives the byte-lane enables for the bytes being moved. If it is not, the block rejects the request with a one-cycle error pulse and starts nothing.

Top module: `burst_beat_seq`

## Requirements
- R1: A burst write (req_write=1) presents double-word indices 0, 1, 2, 3 in that order, whatever req_addr[4:3] holds.
- R2: A burst read starts at the double-word index req_addr[4:3]. Each later beat adds one modulo 4, so a start of 2 gives 2, 3, 0, 1.
- R3: A beat advances only on a cycle in which ack is high while the block is busy. Without ack, beat_dw and beat_addr hold their values. An ack while idle has no effect.
- R4: During a burst, beat_addr is the latched line address (bits 31:5) with beat_dw in bits 4:3 and zero in bits 2:0, and lane_en is 8'hFF.
- R5: A single transfer's size code req_size is a one-hot byte count: 4'b0001=1, 4'b0010=2, 4'b0100=4, 4'b1000=8. It is aligned only when req_addr[2:0] is a multiple of the count. Byte transfers are always aligned, and any other code is invalid.
- R6: For an aligned single transfer, lane_en bit (7-k) is set for each byte offset k from req_addr[2:0] to req_addr[2:0]+count-1. Offset 0 is bit 7, which is data bits D[0-7], the most significant lane. beat_addr equals the latched request address.
- R7: A single request that is misaligned or has an invalid size code gives align_err high for exactly the one cycle after acceptance. The block stays idle and lane_en stays 0.
- R8: done is high in the same cycle that the fourth acknowledged beat of a burst, or the acknowledged beat of a single transfer, is accepted. It is high on no other cycle, and busy is low on the next cycle.
- R9: A request is accepted only while idle. A request presented while busy is ignored and does not change the beat sequence.
- R10: Synchronous active-low reset (rst_n=0 at a clock edge) returns the block to idle with busy, done and align_err low and lane_en 0, even in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request, taken while idle |
| req_burst | input | 1 | 1 = four-beat line burst, 0 = single transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_size | input | 4 | One-hot byte count of a single transfer |
| ack | input | 1 | Transfer acknowledge, completes one beat |
| busy | output | 1 | Data phase in progress |
| beat_dw | output | 2 | Double-word index of the current beat |
| beat_addr | output | 32 | Address of the current beat |
| lane_en | output | 8 | Byte-lane enables, bit 7 = D[0-7] |
| done | output | 1 | Final beat acknowledged this cycle |
| align_err | output | 1 | Single request rejected (pulse) |

## Verification
The assertions check several properties on every cycle:
- beats hold without an acknowledge;
- burst indices step by one modulo 4, and writes open at zero;
- the low address bits stay zero in bursts, and the lanes are nonzero while busy;
- busy drops after done, and a rejected request never starts;
- reset leaves the block quiet.

The bench's scenarios cover what needs an expected value built from the request. That includes the read start taken from the critical double-word, the exact lane pattern for each size and offset, and which size and offset pairs are rejected. It also includes the proof that a request made while busy or an ack made while idle changes nothing.

// File: rtl/burst_seq_pkg.sv
// Package: shared types for the burst beat sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package burst_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BURST  = 2'd1,
        ST_SINGLE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/burst_order_ctr.sv
// Module: beat index generator for a wrapping burst.
// It loads a start index, then adds one to it modulo BEATS on each step.
// It separately counts the beats taken so it can flag the last one.
// Assumes: BEATS is a power of two, so the index wraps naturally.
module burst_order_ctr #(
    parameter int BEATS = 4,
    localparam int IW = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [IW-1:0] start_idx,
    input  logic          step,
    output logic [IW-1:0] idx,
    output logic          last
);
    logic [IW-1:0] cnt_q;

    // Purpose: hold the wrapping index and the count of beats taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            cnt_q <= '0;
        end else if (load) begin
            idx   <= start_idx;
            cnt_q <= '0;
        end else if (step) begin
            idx   <= idx + 1'b1;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: flag the final beat of the line.
    always_comb last = (cnt_q == IW'(BEATS - 1));
endmodule

// File: rtl/single_lane_dec.sv
// Module: alignment check and byte-lane decode for a single transfer.
// Lane bit LANES-1 carries byte offset 0, the most significant lane.
// Assumes: size is a one-hot byte count, and any other code is invalid.
module single_lane_dec #(
    parameter int LANES = 8,
    localparam int OW = $clog2(LANES)
) (
    input  logic [OW-1:0]    offset,
    input  logic [3:0]       size,
    output logic             aligned,
    output logic [LANES-1:0] lanes
);
    logic size_ok;

    // Purpose: size must be one-hot, fit the bus, and divide the offset.
    always_comb begin
        size_ok = ($countones(size) == 1) && (int'(size) <= LANES);
        aligned = size_ok && ((int'(offset) % int'(size)) == 0);
    end

    // One enable per lane, counted from the most significant lane down.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int BOFS = LANES - 1 - i;
        // Purpose: enable this lane when its byte lies in the transfer.
        always_comb lanes[i] = aligned && (BOFS >= int'(offset))
                             && (BOFS < int'(offset) + int'(size));
    end
endmodule

// File: rtl/burst_beat_seq.sv
// Module: data-phase sequencer for a 64-bit bus master.
// It runs four-beat wrapping line bursts and single aligned transfers.
// Reads start at the critical double-word. Writes start at double-word zero.
// Each ack completes one beat.
// Assumes: the address phase is handled elsewhere, and a request is a
// one-cycle offer that is taken only while idle.
module burst_beat_seq #(
    parameter int ADDR_W = 32,
    parameter int BEATS  = 4,
    parameter int LANES  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_burst,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [3:0]               req_size,
    input  logic                     ack,
    output logic                     busy,
    output logic [$clog2(BEATS)-1:0] beat_dw,
    output logic [ADDR_W-1:0]        beat_addr,
    output logic [LANES-1:0]         lane_en,
    output logic                     done,
    output logic                     align_err
);
    import burst_seq_pkg::*;

    localparam int OFS_W    = $clog2(LANES);
    localparam int IDX_W    = $clog2(BEATS);
    localparam int LINE_LSB = OFS_W + IDX_W;

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [LANES-1:0]  lane_q;
    logic              err_q;
    logic              burst_q;
    logic              accept;
    logic              aligned_now;
    logic [LANES-1:0]  lanes_now;
    logic [IDX_W-1:0]  start_idx;
    logic [IDX_W-1:0]  idx;
    logic              last;
    logic              step;

    // Purpose: decode alignment and lanes of the offered single request.
    single_lane_dec #(.LANES(LANES)) u_dec (
        .offset  (req_addr[OFS_W-1:0]),
        .size    (req_size),
        .aligned (aligned_now),
        .lanes   (lanes_now)
    );

    // Purpose: pick the first beat from the direction.
    always_comb begin
        accept    = (state_q == ST_IDLE) && req_valid;
        start_idx = req_write ? '0 : req_addr[LINE_LSB-1:OFS_W];
        step      = (state_q == ST_BURST) && ack;
        burst_q   = (state_q == ST_BURST);
    end

    // Purpose: generate the wrapping double-word index.
    burst_order_ctr #(.BEATS(BEATS)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && req_burst),
        .start_idx (start_idx),
        .step      (step),
        .idx       (idx),
        .last      (last)
    );

    // Purpose: control state, latched request fields and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            write_q <= 1'b0;
            lane_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    addr_q  <= req_addr;
                    write_q <= req_write;
                    lane_q  <= lanes_now;
                    if (req_burst)        state_q <= ST_BURST;
                    else if (aligned_now) state_q <= ST_SINGLE;
                    else                  err_q   <= 1'b1;
                end
                ST_BURST:  if (ack && last) state_q <= ST_IDLE;
                ST_SINGLE: if (ack)         state_q <= ST_IDLE;
                default:                    state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive beat address, lanes and completion from state.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        align_err = err_q;
        done      = (burst_q && ack && last) || ((state_q == ST_SINGLE) && ack);
        beat_dw   = burst_q ? idx : '0;
        if (burst_q) begin
            beat_addr = {addr_q[ADDR_W-1:LINE_LSB], idx, {OFS_W{1'b0}}};
            lane_en   = '1;
        end else if (state_q == ST_SINGLE) begin
            beat_addr = addr_q;
            lane_en   = lane_q;
        end else begin
            beat_addr = '0;
            lane_en   = '0;
        end
    end
endmodule

// File: rtl/burst_beat_seq_chk.sv
// Module: checker for the burst beat sequencer, attached by bind.
// Assumes: the default geometry of four beats, eight lanes and 32-bit addresses.
module burst_beat_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ack,
    input logic        busy,
    input logic [1:0]  beat_dw,
    input logic [31:0] beat_addr,
    input logic [7:0]  lane_en,
    input logic        done,
    input logic        align_err,
    input logic        burst_q,
    input logic        write_q
);
    // R3: with no ack, the beat holds.
    a_r3_hold_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack) |=> (busy && $stable(beat_dw) && $stable(beat_addr)));

    // R2: burst beats advance by one, modulo 4.
    a_r2_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && burst_q && ack && !done) |=> (beat_dw == 2'($past(beat_dw) + 2'd1)));

    // R1: a burst write opens at double-word zero.
    a_r1_write_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && burst_q && write_q) |-> (beat_dw == 2'd0));

    // R4: burst low address bits are zero and all lanes are on.
    a_r4_burst_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && burst_q) |-> (beat_addr[2:0] == 3'b000 && lane_en == 8'hFF));

    // R6: an accepted single transfer enables at least one lane.
    a_r6_lanes_live: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lane_en != 8'h00));

    // R7: a rejected request never starts.
    a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (!busy && lane_en == 8'h00));

    // R8: done ends the data phase.
    a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8: done only with an ack while busy.
    a_r8_done_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && ack));

    // R10: reset leaves the block quiet.
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!busy && lane_en == 8'h00 && !align_err));
endmodule

bind burst_beat_seq burst_beat_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .busy      (busy),
    .beat_dw   (beat_dw),
    .beat_addr (beat_addr),
    .lane_en   (lane_en),
    .done      (done),
    .align_err (align_err),
    .burst_q   (burst_q),
    .write_q   (write_q)
);

// File: tb/burst_beat_seq_tb_top.sv
// Bench: directed scenarios for the burst beat sequencer.
// Inputs change on the falling edge, and outputs are sampled there too.
module burst_beat_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_burst = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_size = 4'b0001;
    logic        ack = 1'b0;
    logic        busy;
    logic [1:0]  beat_dw;
    logic [31:0] beat_addr;
    logic [7:0]  lane_en;
    logic        done;
    logic        align_err;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_beat_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_burst(req_burst),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .ack(ack),
        .busy(busy), .beat_dw(beat_dw), .beat_addr(beat_addr), .lane_en(lane_en),
        .done(done), .align_err(align_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic offer(input bit burst, input bit wr, input logic [31:0] a,
                         input logic [3:0] sz);
        req_valid = 1'b1; req_burst = burst; req_write = wr; req_addr = a; req_size = sz;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // R1 R2 R3 R4 R8: run one burst, with `gap` idle cycles before each ack.
    task automatic run_burst(input bit wr, input logic [31:0] a, input int gap,
                             input string req);
        logic [1:0] start = wr ? 2'd0 : a[4:3];
        offer(1'b1, wr, a, 4'b1000);
        for (int k = 0; k < 4; k++) begin
            logic [1:0] e = 2'(start + 2'(k));
            check(busy, req, "busy", busy, 1);
            check(beat_dw == e, req, "beat_dw", beat_dw, e);
            check(beat_addr == {a[31:5], e, 3'b000}, "R4", "beat_addr", beat_addr,
                  {a[31:5], e, 3'b000});
            check(lane_en == 8'hFF, "R4", "lane_en", lane_en, 8'hFF);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                check(beat_dw == e && !done, "R3", "stall", beat_dw, e);
            end
            ack = 1'b1;
            #1;
            check(done == (k == 3), "R8", "done", done, (k == 3));
            @(negedge clk);
            ack = 1'b0;
        end
        check(!busy && !done, "R8", "idle after burst", busy, 0);
    endtask

    // R5 R6 R7 R8: one single transfer, checked against computed lanes.
    task automatic run_single(input logic [31:0] a, input logic [3:0] sz, input string req);
        int n = int'(sz);
        int off = int'(a[2:0]);
        bit ok = ($countones(sz) == 1) && (n <= 8) && (off % n == 0);
        logic [7:0] el = '0;
        if (ok) for (int b = off; b < off + n; b++) el[7-b] = 1'b1;
        offer(1'b0, 1'b0, a, sz);
        if (!ok) begin
            check(align_err && !busy && lane_en == 0, "R7", "rejected", align_err, 1);
            @(negedge clk);
            check(!align_err && !busy, "R7", "pulse one cycle", align_err, 0);
        end else begin
            check(busy && !align_err, req, "started", busy, 1);
            check(lane_en == el, "R6", "lane_en", lane_en, el);
            check(beat_addr == a, "R6", "beat_addr", beat_addr, a);
            ack = 1'b1;
            #1;
            check(done, "R8", "single done", done, 1);
            @(negedge clk);
            ack = 1'b0;
            check(!busy && lane_en == 0, "R8", "idle after single", busy, 0);
        end
    endtask

    // R10: reset state.
    task automatic test_reset();
        @(negedge clk);
        check(!busy && lane_en == 0 && !done && !align_err, "R10", "reset state", lane_en, 0);
    endtask

    // R3: an ack while idle changes nothing.
    task automatic test_idle_ack();
        ack = 1'b1;
        @(negedge clk);
        check(!busy && !done && lane_en == 0, "R3", "idle ack", busy, 0);
        ack = 1'b0;
        run_burst(1'b0, 32'h0000_1008, 0, "R3");
    endtask

    // R9: a request while busy is ignored.
    task automatic test_busy_req();
        offer(1'b1, 1'b0, 32'h0000_2010, 4'b1000);
        req_valid = 1'b1; req_burst = 1'b0; req_write = 1'b1; req_addr = 32'h0000_3005;
        req_size = 4'b0001;
        ack = 1'b1;
        for (int k = 0; k < 4; k++) begin
            logic [1:0] e = 2'(2 + k);
            check(beat_dw == e && beat_addr[31:5] == 27'h100, "R9", "sequence kept",
                  beat_dw, e);
            @(negedge clk);
        end
        req_valid = 1'b0; ack = 1'b0;
        check(!busy, "R9", "no extra transfer", busy, 0);
    endtask

    // R10: reset in the middle of a burst.
    task automatic test_mid_reset();
        offer(1'b1, 1'b1, 32'h0000_4000, 4'b1000);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && lane_en == 0 && !done, "R10", "mid-burst reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R10", "stays idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_burst(1'b1, 32'h0000_0110, 0, "R1");
        run_burst(1'b0, 32'h0000_0110, 0, "R2");
        run_burst(1'b0, 32'h8000_0418, 2, "R2");
        run_burst(1'b0, 32'h0000_0048, 1, "R3");
        test_idle_ack();
        run_single(32'h0000_0100, 4'b0001, "R6");
        run_single(32'h0000_0107, 4'b0001, "R6");
        run_single(32'h0000_0106, 4'b0010, "R5");
        run_single(32'h0000_0104, 4'b0100, "R5");
        run_single(32'h0000_0100, 4'b1000, "R5");
        run_single(32'h0000_0102, 4'b0100, "R7");
        run_single(32'h0000_0101, 4'b0010, "R7");
        run_single(32'h0000_0104, 4'b1000, "R7");
        run_single(32'h0000_0100, 4'b0011, "R7");
        test_busy_req();
        test_mid_reset();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule